// File: doc/BRIEF.md
# Coarse Presearch Engine

This block runs the first, coarsest stage of a hierarchical integer motion search for one macroblock. At this stage both the current macroblock and the reference picture have already been reduced 16:1, so the block being matched is 4x4 pixels. Every candidate displacement in a window of ±SR_X by ±SR_Y coarse pixels is scored, which is ±32 by ±24 by default and corresponds to ±128 by ±96 at full resolution. The four lowest-cost candidates are kept, and a finer refinement stage uses them as search centres.

A search opens with a one-cycle `start` pulse. That pulse captures the 4x4 current block, a predicted vector and a rate weight. The reference window then arrives one row per transfer over a valid/ready stream, top row first. Once four rows are held, each newly accepted row adds a fresh line of vertical candidates. That line is scored by four parallel ways, and each way handles four horizontally adjacent candidates, so sixteen candidates are scored per cycle. While a line is being scored the block holds `ref_ready` low. A source that keeps `ref_valid` high simply waits, with its row left untouched. After the last row has been scored, `done` pulses and the four results stay on the outputs until the next `start`.

Top module: `coarse_presearch`

## Requirements
- R1: While reset is held and after it is released, `ref_ready` and `done` are 0 and every slot of `best_cost`, `best_mvx` and `best_mvy` reads 0.
- R2: A row is taken only on a cycle where `ref_valid` and `ref_ready` are both 1. `ref_ready` is 1 only while the block is waiting for a row, and a row offered while it is 0 has no effect on the results. After each accepted row from the fourth onward, `ref_ready` stays 0 for exactly NPASS = ceil((2*SR_X+1)/16) cycles, which is 5 by default.
- R3: Every candidate (dx, dy) with dx in -SR_X..SR_X and dy in -SR_Y..SR_Y is scored. Its SAD is the sum over r,c in 0..3 of |cur(r,c) - ref(dy+SR_Y+r, dx+SR_X+c)|. Pixel cur(r,c) sits at bits [(4r+c)*8 +: 8] of `cur_blk`, pixel column k of a row sits at bits [8k +: 8] of `ref_row`, and row 0 is the first row sent.
- R4: Cost = SAD + lambda * (|dx - pred_x| + |dy - pred_y|), with all vectors in coarse units and `pred_x` and `pred_y` in two's complement.
- R5: Slot 0 of each output holds the lowest cost. The four slots hold the four lowest-cost candidates in non-decreasing cost order, and slot i occupies bits [i*W +: W] of each output bus.
- R6: On equal cost, the candidate that comes earlier in scan order is ranked higher. Scan order is dy ascending first, then dx ascending.
- R7: Reported vectors are in full-pel units: `best_mvx` is 4*dx and `best_mvy` is 4*dy, each as a 9-bit two's complement value.
- R8: `done` is high for exactly one cycle, 1 + NPASS cycles after the last row is accepted, and the result outputs stay unchanged until the next `start`.
- R9: A `start` pulse abandons any search in progress. The results that follow depend only on the data of the new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search; captures block, predictor, weight |
| cur_blk | input | 128 | Downsampled 4x4 current block |
| pred_x | input | 8 | Predicted horizontal vector, coarse units, signed |
| pred_y | input | 8 | Predicted vertical vector, coarse units, signed |
| lambda | input | 8 | Rate weight |
| ref_valid | input | 1 | Reference row offered |
| ref_ready | output | 1 | Block can take a reference row |
| ref_row | input | 544 | One reference row of 2*SR_X+4 pixels |
| done | output | 1 | One-cycle pulse when the results are final |
| best_cost | output | 124 | Four costs, 31 bits each |
| best_mvx | output | 36 | Four horizontal vectors, 9 bits each, full-pel |
| best_mvy | output | 36 | Four vertical vectors, 9 bits each, full-pel |

## Verification
The assertions rely on the source sending exactly 2*SR_Y+4 rows after each `start`. They also assume that `start` is not raised again before `done`, except when a restart is intended. The checks that say `done` leaves all four slots filled and that ready falls after a scoring row depend on that count. The stimulus applies `start` only as a single-cycle pulse, sends exactly the full row count except in the deliberate restart case, and drives random rows with `ref_valid` high during stall windows.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EVAL} cps_state_e;
  localparam int CPS_BLK = 4;
endpackage

// File: rtl/cps_sad_way.sv
module cps_sad_way #(
  parameter int PIX_W = 8,
  parameter int CPW   = 4,
  parameter int BLK   = 4,
  parameter int SAD_W = 12,
  localparam int WCOL = CPW + BLK - 1
) (
  input  logic [BLK*BLK*PIX_W-1:0]  cur,
  input  logic [BLK*WCOL*PIX_W-1:0] win,
  output logic [CPW*SAD_W-1:0]      sad
);
  for (genvar k = 0; k < CPW; k++) begin : g_cand
    logic [SAD_W-1:0] acc;
    always_comb begin
      logic [PIX_W-1:0] a, b;
      acc = '0;
      for (int r = 0; r < BLK; r++) begin
        for (int c = 0; c < BLK; c++) begin
          a = cur[(r*BLK+c)*PIX_W +: PIX_W];
          b = win[(r*WCOL+c+k)*PIX_W +: PIX_W];
          acc = acc + SAD_W'(a > b ? a - b : b - a);
        end
      end
    end
    assign sad[k*SAD_W +: SAD_W] = acc;
  end
endmodule

// File: rtl/cps_best_list.sv
module cps_best_list #(
  parameter int NLIST  = 4,
  parameter int NNEW   = 16,
  parameter int COST_W = 31,
  parameter int MV_W   = 7,
  localparam int NTOT  = NLIST + NNEW,
  localparam int RK_W  = $clog2(NTOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic [NNEW-1:0]        new_vld,
  input  logic [NNEW*COST_W-1:0] new_cost,
  input  logic [NNEW*MV_W-1:0]   new_x,
  input  logic [NNEW*MV_W-1:0]   new_y,
  output logic [NLIST-1:0]       list_vld,
  output logic [NLIST*COST_W-1:0] list_cost,
  output logic [NLIST*MV_W-1:0]  list_x,
  output logic [NLIST*MV_W-1:0]  list_y
);
  logic [NTOT-1:0]   e_vld;
  logic [COST_W-1:0] e_cost [NTOT];
  logic [MV_W-1:0]   e_x    [NTOT];
  logic [MV_W-1:0]   e_y    [NTOT];
  logic [RK_W-1:0]   rank   [NTOT];
  logic [NLIST-1:0]       n_vld;
  logic [NLIST*COST_W-1:0] n_cost;
  logic [NLIST*MV_W-1:0]  n_x, n_y;

  // Entries ordered: held list first (earlier in scan), then new candidates.
  always_comb begin
    for (int i = 0; i < NTOT; i++) begin
      if (i < NLIST) begin
        e_vld[i]  = list_vld[i];
        e_cost[i] = list_cost[i*COST_W +: COST_W];
        e_x[i]    = list_x[i*MV_W +: MV_W];
        e_y[i]    = list_y[i*MV_W +: MV_W];
      end else begin
        e_vld[i]  = new_vld[i-NLIST];
        e_cost[i] = new_cost[(i-NLIST)*COST_W +: COST_W];
        e_x[i]    = new_x[(i-NLIST)*MV_W +: MV_W];
        e_y[i]    = new_y[(i-NLIST)*MV_W +: MV_W];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NTOT; j++) begin
      rank[j] = '0;
      for (int i = 0; i < NTOT; i++) begin
        if (i != j && e_vld[i] &&
            (!e_vld[j] || e_cost[i] < e_cost[j] || (e_cost[i] == e_cost[j] && i < j)))
          rank[j] = rank[j] + RK_W'(1);
      end
    end
  end

  always_comb begin
    n_vld = '0; n_cost = '0; n_x = '0; n_y = '0;
    for (int s = 0; s < NLIST; s++) begin
      for (int j = 0; j < NTOT; j++) begin
        if (e_vld[j] && rank[j] == RK_W'(s)) begin
          n_vld[s] = 1'b1;
          n_cost[s*COST_W +: COST_W] = e_cost[j];
          n_x[s*MV_W +: MV_W] = e_x[j];
          n_y[s*MV_W +: MV_W] = e_y[j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      list_vld <= '0; list_cost <= '0; list_x <= '0; list_y <= '0;
    end else if (en) begin
      list_vld <= n_vld; list_cost <= n_cost; list_x <= n_x; list_y <= n_y;
    end
  end

  for (genvar s = 0; s < NLIST-1; s++) begin : g_chk
    AST_LIST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
      list_vld[s+1] |-> (list_vld[s] &&
        list_cost[s*COST_W +: COST_W] <= list_cost[(s+1)*COST_W +: COST_W])); // R5
  end
  AST_BEST_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && list_vld[0]) |=> (list_cost[COST_W-1:0] <= $past(list_cost[COST_W-1:0]))); // R5
endmodule

// File: rtl/coarse_presearch.sv
module coarse_presearch
  import cps_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SR_X  = 32,
  parameter int SR_Y  = 24,
  parameter int WAYS  = 4,
  parameter int CPW   = 4,
  parameter int LAM_W = 8,
  parameter int PMV_W = 8,
  parameter int NBEST = 4,
  localparam int BLK     = CPS_BLK,
  localparam int NCX     = 2*SR_X + 1,
  localparam int NCY     = 2*SR_Y + 1,
  localparam int ROW_PIX = NCX + BLK - 1,
  localparam int NROWS   = NCY + BLK - 1,
  localparam int SAD_W   = PIX_W + 4,
  localparam int CMV_W   = $clog2(SR_X > SR_Y ? SR_X : SR_Y) + 2,
  localparam int DIFF_W  = (CMV_W > PMV_W ? CMV_W : PMV_W) + 2,
  localparam int COST_W  = SAD_W + LAM_W + DIFF_W + 1,
  localparam int MV_W    = CMV_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BLK*BLK*PIX_W-1:0] cur_blk,
  input  logic [PMV_W-1:0]         pred_x,
  input  logic [PMV_W-1:0]         pred_y,
  input  logic [LAM_W-1:0]         lambda,
  input  logic                     ref_valid,
  output logic                     ref_ready,
  input  logic [ROW_PIX*PIX_W-1:0] ref_row,
  output logic                     done,
  output logic [NBEST*COST_W-1:0]  best_cost,
  output logic [NBEST*MV_W-1:0]    best_mvx,
  output logic [NBEST*MV_W-1:0]    best_mvy
);
  localparam int CPC     = WAYS * CPW;
  localparam int NPASS   = (NCX + CPC - 1) / CPC;
  localparam int BUF_PIX = NPASS*CPC + BLK - 1;
  localparam int WCOL    = CPW + BLK - 1;
  localparam int BI_W    = $clog2(BUF_PIX);
  localparam int RC_W    = $clog2(NROWS + 1);
  localparam int PC_W    = $clog2(NPASS + 1);

  cps_state_e               state;
  logic [RC_W-1:0]          rcnt;
  logic [PC_W-1:0]          pcnt;
  logic [BLK*BLK*PIX_W-1:0] cur_q;
  logic signed [PMV_W-1:0]  px_q, py_q;
  logic [LAM_W-1:0]         lam_q;
  logic [PIX_W-1:0]         rbuf [BLK][BUF_PIX];
  logic                     accept, eval_en;
  logic [BLK*WCOL*PIX_W-1:0] way_win [WAYS];
  logic [CPC*SAD_W-1:0]     sad_all;
  logic [CPC-1:0]           c_vld;
  logic [CPC*COST_W-1:0]    c_cost;
  logic [CPC*CMV_W-1:0]     c_x, c_y;
  logic [NBEST-1:0]         l_vld;
  logic [NBEST*CMV_W-1:0]   l_x, l_y;

  assign ref_ready = (state == ST_LOAD) && !start;
  assign accept    = ref_valid && ref_ready;
  assign eval_en   = (state == ST_EVAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; rcnt <= '0; pcnt <= '0; done <= 1'b0;
      cur_q <= '0; px_q <= '0; py_q <= '0; lam_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cur_q <= cur_blk; px_q <= pred_x; py_q <= pred_y; lam_q <= lambda;
        rcnt <= '0; pcnt <= '0; state <= ST_LOAD;
      end else begin
        case (state)
          ST_LOAD: if (accept) begin
            rcnt <= rcnt + RC_W'(1);
            if (rcnt + RC_W'(1) >= RC_W'(BLK)) begin
              state <= ST_EVAL; pcnt <= '0;
            end
          end
          ST_EVAL: if (pcnt == PC_W'(NPASS-1)) begin
            pcnt <= '0;
            if (rcnt == RC_W'(NROWS)) begin
              state <= ST_IDLE; done <= 1'b1;
            end else begin
              state <= ST_LOAD;
            end
          end else begin
            pcnt <= pcnt + PC_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // Four-row line buffer; newest row at index BLK-1, zero padded on the right.
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int r = 0; r < BLK-1; r++) rbuf[r] <= rbuf[r+1];
      for (int c = 0; c < BUF_PIX; c++)
        rbuf[BLK-1][c] <= (c < ROW_PIX) ? ref_row[c*PIX_W +: PIX_W] : '0;
    end
  end

  always_comb begin
    logic [BI_W-1:0] idx;
    for (int w = 0; w < WAYS; w++) begin
      for (int r = 0; r < BLK; r++) begin
        for (int c = 0; c < WCOL; c++) begin
          idx = BI_W'(int'(pcnt)*CPC + w*CPW + c);
          way_win[w][(r*WCOL+c)*PIX_W +: PIX_W] = rbuf[r][idx];
        end
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cps_sad_way #(.PIX_W(PIX_W), .CPW(CPW), .BLK(BLK), .SAD_W(SAD_W)) u_way (
      .cur (cur_q),
      .win (way_win[w]),
      .sad (sad_all[w*CPW*SAD_W +: CPW*SAD_W])
    );
  end

  always_comb begin
    int xi, dx, dy, ax, ay;
    for (int j = 0; j < CPC; j++) begin
      xi = int'(pcnt)*CPC + j;
      dx = xi - SR_X;
      dy = int'(rcnt) - BLK - SR_Y;
      ax = dx - int'(px_q); if (ax < 0) ax = -ax;
      ay = dy - int'(py_q); if (ay < 0) ay = -ay;
      c_vld[j] = eval_en && (xi < NCX);
      c_cost[j*COST_W +: COST_W] =
        COST_W'(int'(sad_all[j*SAD_W +: SAD_W]) + int'(lam_q) * (ax + ay));
      c_x[j*CMV_W +: CMV_W] = CMV_W'(dx);
      c_y[j*CMV_W +: CMV_W] = CMV_W'(dy);
    end
  end

  cps_best_list #(.NLIST(NBEST), .NNEW(CPC), .COST_W(COST_W), .MV_W(CMV_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(eval_en),
    .new_vld(c_vld), .new_cost(c_cost), .new_x(c_x), .new_y(c_y),
    .list_vld(l_vld), .list_cost(best_cost), .list_x(l_x), .list_y(l_y)
  );

  for (genvar s = 0; s < NBEST; s++) begin : g_out
    assign best_mvx[s*MV_W +: MV_W] = {l_x[s*CMV_W +: CMV_W], 2'b00};
    assign best_mvy[s*MV_W +: MV_W] = {l_y[s*CMV_W +: CMV_W], 2'b00};
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&l_vld)); // R5
  AST_STALL_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start && rcnt >= RC_W'(BLK-1)) |=> !ref_ready); // R2
  AST_NO_TAKE_WHILE_SCORING: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en |-> !ref_ready); // R2
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !start && state == ST_IDLE) |-> $stable(best_cost)); // R8
endmodule

// File: tb/coarse_presearch_tb.sv
module coarse_presearch_tb;
  localparam int PIX_W = 8, SR_X = 32, SR_Y = 24, BLK = 4;
  localparam int NCX = 2*SR_X+1, NCY = 2*SR_Y+1;
  localparam int ROW_PIX = NCX+BLK-1, NROWS = NCY+BLK-1;
  localparam int NPASS = (NCX+15)/16;
  localparam int CMV_W = 7, MV_W = 9, COST_W = 31, NB = 4;

  logic clk = 0, rst_n = 0, start = 0, ref_valid = 0;
  logic [BLK*BLK*PIX_W-1:0] cur_blk = '0;
  logic [7:0] pred_x = '0, pred_y = '0, lambda = '0;
  logic ref_ready, done;
  logic [ROW_PIX*PIX_W-1:0] ref_row = '0;
  logic [NB*COST_W-1:0] best_cost;
  logic [NB*MV_W-1:0] best_mvx, best_mvy;

  coarse_presearch u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_blk(cur_blk),
    .pred_x(pred_x), .pred_y(pred_y), .lambda(lambda),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row),
    .done(done), .best_cost(best_cost), .best_mvx(best_mvx), .best_mvy(best_mvy)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int cur_m [16];
  int ref_m [NROWS][ROW_PIX];
  int lam_m, pdx_m, pdy_m;
  int exp_c [NB], exp_x [NB], exp_y [NB];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired act %0d exp below 150000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string rq, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", rq, act, expv);
    end
  endtask

  function automatic int iabs(int v); return v < 0 ? -v : v; endfunction

  function automatic void model();
    bit filled [NB];
    for (int s = 0; s < NB; s++) filled[s] = 0;
    for (int dy = -SR_Y; dy <= SR_Y; dy++) begin
      for (int dx = -SR_X; dx <= SR_X; dx++) begin
        int sad = 0, cst, pos;
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++)
            sad += iabs(cur_m[r*4+c] - ref_m[dy+SR_Y+r][dx+SR_X+c]);
        cst = sad + lam_m * (iabs(dx - pdx_m) + iabs(dy - pdy_m));
        pos = NB;
        for (int s = NB-1; s >= 0; s--)
          if (!filled[s] || cst < exp_c[s]) pos = s;
        if (pos < NB) begin
          for (int s = NB-1; s > pos; s--) begin
            exp_c[s] = exp_c[s-1]; exp_x[s] = exp_x[s-1];
            exp_y[s] = exp_y[s-1]; filled[s] = filled[s-1];
          end
          exp_c[pos] = cst; exp_x[pos] = dx; exp_y[pos] = dy; filled[pos] = 1;
        end
      end
    end
  endfunction

  function automatic void fill_random();
    for (int i = 0; i < 16; i++) cur_m[i] = $urandom_range(255);
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < ROW_PIX; c++) ref_m[r][c] = $urandom_range(255);
  endfunction

  function automatic logic [ROW_PIX*PIX_W-1:0] pack_row(int r);
    logic [ROW_PIX*PIX_W-1:0] v;
    for (int c = 0; c < ROW_PIX; c++) v[c*PIX_W +: PIX_W] = 8'(ref_m[r][c]);
    return v;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    for (int i = 0; i < 16; i++) cur_blk[i*8 +: 8] = 8'(cur_m[i]);
    pred_x = 8'(pdx_m); pred_y = 8'(pdy_m); lambda = 8'(lam_m);
    ref_valid = 0; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Sends nrows rows; during stall windows optionally offers random rows.
  task automatic send_rows(int nrows, bit garbage);
    int idx = 0, stall = 0;
    while (idx < nrows) begin
      @(negedge clk);
      if (ref_ready) begin
        if (idx >= BLK) chk("R2 stall length", stall, NPASS);
        stall = 0;
        ref_valid = 1; ref_row = pack_row(idx); idx++;
      end else begin
        stall++;
        ref_valid = garbage;
        for (int c = 0; c < ROW_PIX; c++) ref_row[c*8 +: 8] = 8'($urandom_range(255));
      end
    end
    @(negedge clk);
    ref_valid = 0;
  endtask

  task automatic run_search(string rq, bit garbage);
    int w = 0, after = 0;
    int hold_c;
    model();
    pulse_start();
    send_rows(NROWS, garbage);
    after = 1;
    while (!done && w < 2000) begin @(negedge clk); w++; after++; end
    chk("R8 done arrives", int'(done), 1);
    chk("R8 done latency", after, 1 + NPASS);
    for (int s = 0; s < NB; s++) begin
      chk(rq, int'(best_cost[s*COST_W +: COST_W]), exp_c[s]);
      chk("R7 mvx", int'($signed(best_mvx[s*MV_W +: MV_W])), 4*exp_x[s]);
      chk("R7 mvy", int'($signed(best_mvy[s*MV_W +: MV_W])), 4*exp_y[s]);
    end
    hold_c = int'(best_cost[COST_W-1:0]);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R8 results held", int'(best_cost[COST_W-1:0]), hold_c);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(ref_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", int'(ref_ready), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 costs zero", int'(best_cost == '0), 1);
    chk("R1 vectors zero", int'(best_mvx == '0 && best_mvy == '0), 1);

    // R3 / R5: random pixels, pure SAD
    fill_random(); lam_m = 0; pdx_m = 0; pdy_m = 0;
    run_search("R3 R5 random SAD", 0);

    // R6: flat picture, every cost equal, first four in scan order win
    for (int i = 0; i < 16; i++) cur_m[i] = 100;
    for (int r = 0; r < NROWS; r++) for (int c = 0; c < ROW_PIX; c++) ref_m[r][c] = 100;
    run_search("R6 tie order", 0);
    chk("R6 first slot dx", int'($signed(best_mvx[MV_W-1:0])), -4*SR_X);
    chk("R6 fourth slot dx", int'($signed(best_mvx[3*MV_W +: MV_W])), -4*SR_X + 12);

    // R4: rate weight with a nonzero predictor
    fill_random(); lam_m = 4; pdx_m = 5; pdy_m = -3;
    run_search("R4 lambda cost", 0);

    // R4: flat picture with a predictor; best must sit on the predictor
    for (int i = 0; i < 16; i++) cur_m[i] = 7;
    for (int r = 0; r < NROWS; r++) for (int c = 0; c < ROW_PIX; c++) ref_m[r][c] = 7;
    lam_m = 9; pdx_m = -11; pdy_m = 20;
    run_search("R4 predictor bias", 0);
    chk("R4 best at predictor x", int'($signed(best_mvx[MV_W-1:0])), -44);

    // R3 corner: exact match planted at the far corner (last, partial pass)
    fill_random(); lam_m = 0; pdx_m = 0; pdy_m = 0;
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++)
      ref_m[2*SR_Y+r][2*SR_X+c] = cur_m[r*4+c];
    run_search("R3 corner match", 1);
    chk("R3 corner cost", int'(best_cost[COST_W-1:0]), 0);

    // R2: random rows offered while stalled must be ignored
    fill_random(); lam_m = 2; pdx_m = 1; pdy_m = 2;
    run_search("R2 ignored rows", 1);

    // R9: abandon a search part way, then run a fresh one
    fill_random(); lam_m = 0; pdx_m = 0; pdy_m = 0;
    pulse_start();
    send_rows(20, 1);
    fill_random(); lam_m = 3; pdx_m = -7; pdy_m = 6;
    run_search("R9 restart", 1);

    for (int t = 0; t < 4; t++) begin
      fill_random(); lam_m = $urandom_range(15);
      pdx_m = $urandom_range(40) - 20; pdy_m = $urandom_range(30) - 15;
      run_search("R5 random mix", t[0]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule